// File: doc/BRIEF.md
# Breathing LED Set-Point PWM

This block drives a single LED with a pulse-width modulated signal whose brightness glides through a repeating list of eight programmable levels. A free-running counter makes a triangle wave. The LED is compared against a duty level: it is driven high while the triangle is below the level and low while the triangle is above it.

The duty level does not jump between set points. A prescale counter lets it move only once every 2^DLY_W clocks, and each such move is a single count toward the next set point in the list. When the level arrives at that set point, the list index advances, and it returns to the first entry after the eighth. The set points are fixed at elaboration through one packed parameter. The block runs from the timer clock and has an optional synchronous reset.

Top module: `breathe_pwm`

## Requirements
- R1: While `rst` is high on a rising clock edge, the block clears the triangle counter, the prescale counter and the list index, loads the duty level with set point 0 and drives `led` low.
- R2: The 8-bit triangle counter increments on every clock. The compared triangle value is its low 7 bits when bit 7 is 0 and the bitwise inverse of the low 7 bits when bit 7 is 1.
- R3: On each clock `led` becomes 0 if the triangle value is greater than the duty level, becomes 1 if it is less, and keeps its value if the two are equal.
- R4: Set point k is taken from bits 7k+6 down to 7k of the `SETPTS` parameter. The set point after index k is index k+1, and index 7 is followed by index 0.
- R5: The duty level and the list index change only on clocks where the DLY_W-bit prescale counter, which increments on every clock, is zero.
- R6: On a prescale tick where the duty level equals the next set point, the index advances by one and wraps from 7 to 0. The level does not move on that tick.
- R7: On a prescale tick where the level has not reached the next set point, the level rises by one if the current set point is below the next one and falls by one if it is above it.
- R8: When the current and next set points are equal, the level holds and the index advances on the following tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous reset, active high |
| led | output | 1 | PWM drive for the LED |

## Verification
The hardest case to reach from the pins is the wrap from the eighth set point back to the first. It only occurs after every segment of the list has been ramped through, and the duty level is visible only through the PWM pattern. The bench shortens the prescaler and chooses a list that contains a rising run, a falling run, two pairs of equal neighbours and both extremes 0 and 127. It then runs through the whole list more than once. A reference model predicts the LED value for every cycle, so each step, hold and wrap is checked through the pin.

// File: rtl/breathe_pkg.sv
package breathe_pkg;
    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_UP   = 2'd1,
        RAMP_DOWN = 2'd2
    } ramp_dir_e;
endpackage

// File: rtl/breathe_tri_gen.sv
module breathe_tri_gen #(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    output logic [LVL_W:0]   cnt_o,
    output logic [LVL_W-1:0] tri_o
);
    localparam int CNT_W = LVL_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tri_st_t;

    tri_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // the top bit folds the ramp into a triangle
    assign tri_o = st_q.cnt[CNT_W-1] ? ~st_q.cnt[LVL_W-1:0] : st_q.cnt[LVL_W-1:0];
    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/breathe_setpt_sel.sv
module breathe_setpt_sel #(
    parameter int                        LVL_W  = 7,
    parameter int                        NPTS   = 8,
    parameter logic [NPTS*LVL_W-1:0]     SETPTS = '0,
    localparam int                       IDX_W  = $clog2(NPTS)
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [IDX_W-1:0] nxt_idx_o,
    output logic [LVL_W-1:0] cur_o,
    output logic [LVL_W-1:0] nxt_o,
    output logic [LVL_W-1:0] first_o
);
    logic [LVL_W-1:0] pts [NPTS];

    genvar k;
    generate
        for (k = 0; k < NPTS; k++) begin : g_unpack
            assign pts[k] = SETPTS[k*LVL_W +: LVL_W];
        end
    endgenerate

    always_comb begin
        if (idx_i == IDX_W'(NPTS - 1)) nxt_idx_o = '0;
        else                            nxt_idx_o = idx_i + IDX_W'(1);
    end

    assign cur_o   = pts[idx_i];
    assign nxt_o   = pts[nxt_idx_o];
    assign first_o = pts[0];
endmodule

// File: rtl/breathe_ramp.sv
module breathe_ramp
    import breathe_pkg::*;
#(
    parameter int LVL_W = 7,
    parameter int NPTS  = 8,
    parameter int DLY_W = 10,
    localparam int IDX_W = $clog2(NPTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] cur_i,
    input  logic [LVL_W-1:0] nxt_i,
    input  logic [LVL_W-1:0] first_i,
    input  logic [IDX_W-1:0] nxt_idx_i,
    output logic [LVL_W-1:0] lvl_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [DLY_W-1:0] dly_o
);
    typedef struct packed {
        logic [DLY_W-1:0] dly;
        logic [IDX_W-1:0] idx;
        logic [LVL_W-1:0] lvl;
    } ramp_st_t;

    ramp_st_t  st_d, st_q;
    ramp_dir_e dir;
    logic      tick;

    always_comb begin
        if (cur_i < nxt_i)      dir = RAMP_UP;
        else if (cur_i > nxt_i) dir = RAMP_DOWN;
        else                    dir = RAMP_HOLD;
    end

    assign tick = (st_q.dly == '0);

    always_comb begin
        st_d     = st_q;
        st_d.dly = st_q.dly + DLY_W'(1);
        if (tick) begin
            if (st_q.lvl == nxt_i) begin
                st_d.idx = nxt_idx_i;
            end else begin
                unique case (dir)
                    RAMP_UP:   st_d.lvl = st_q.lvl + LVL_W'(1);
                    RAMP_DOWN: st_d.lvl = st_q.lvl - LVL_W'(1);
                    default:   st_d.lvl = st_q.lvl;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.dly <= '0;
            st_q.idx <= '0;
            st_q.lvl <= first_i;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o = st_q.lvl;
    assign idx_o = st_q.idx;
    assign dly_o = st_q.dly;
endmodule

// File: rtl/breathe_pwm_cmp.sv
module breathe_pwm_cmp #(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] tri_i,
    input  logic [LVL_W-1:0] lvl_i,
    output logic             led_o
);
    logic led_d, led_q;

    always_comb begin
        led_d = led_q;
        if (tri_i > lvl_i)      led_d = 1'b0;
        else if (tri_i < lvl_i) led_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) led_q <= 1'b0;
        else     led_q <= led_d;
    end

    assign led_o = led_q;
endmodule

// File: rtl/breathe_pwm.sv
module breathe_pwm #(
    parameter int                    LVL_W  = 7,
    parameter int                    NPTS   = 8,
    parameter int                    DLY_W  = 10,
    parameter logic [NPTS*LVL_W-1:0] SETPTS = {7'h10, 7'h60, 7'h30, 7'h50, 7'h40, 7'h18, 7'h10, 7'h30}
) (
    input  logic clk,
    input  logic rst,
    output logic led
);
    localparam int IDX_W = $clog2(NPTS);

    logic [LVL_W:0]   cnt_q;
    logic [LVL_W-1:0] tri_v;
    logic [LVL_W-1:0] lvl_q;
    logic [IDX_W-1:0] idx_q;
    logic [DLY_W-1:0] dly_q;
    logic [IDX_W-1:0] nxt_idx;
    logic [LVL_W-1:0] cur_pt, nxt_pt, first_pt;

    breathe_tri_gen #(.LVL_W(LVL_W)) u_tri (
        .clk(clk), .rst(rst), .cnt_o(cnt_q), .tri_o(tri_v)
    );

    breathe_setpt_sel #(.LVL_W(LVL_W), .NPTS(NPTS), .SETPTS(SETPTS)) u_sel (
        .idx_i(idx_q), .nxt_idx_o(nxt_idx), .cur_o(cur_pt),
        .nxt_o(nxt_pt), .first_o(first_pt)
    );

    breathe_ramp #(.LVL_W(LVL_W), .NPTS(NPTS), .DLY_W(DLY_W)) u_ramp (
        .clk(clk), .rst(rst), .cur_i(cur_pt), .nxt_i(nxt_pt),
        .first_i(first_pt), .nxt_idx_i(nxt_idx),
        .lvl_o(lvl_q), .idx_o(idx_q), .dly_o(dly_q)
    );

    breathe_pwm_cmp #(.LVL_W(LVL_W)) u_cmp (
        .clk(clk), .rst(rst), .tri_i(tri_v), .lvl_i(lvl_q), .led_o(led)
    );
endmodule

// File: rtl/breathe_pwm_chk.sv
module breathe_pwm_chk #(
    parameter int LVL_W = 7,
    parameter int IDX_W = 3,
    parameter int DLY_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             led,
    input logic [LVL_W:0]   cnt_q,
    input logic [LVL_W-1:0] lvl_q,
    input logic [IDX_W-1:0] idx_q,
    input logic [DLY_W-1:0] dly_q
);
    logic [LVL_W-1:0] tri_c;
    assign tri_c = cnt_q[LVL_W] ? ~cnt_q[LVL_W-1:0] : cnt_q[LVL_W-1:0];

    // R1
    rst_led_chk: assert property (@(posedge clk) rst |=> !led);

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cnt_q == (LVL_W+1)'($past(cnt_q) + 1'b1));

    // R3
    led_low_chk: assert property (@(posedge clk) disable iff (rst)
        (tri_c > lvl_q) |=> !led);

    // R3
    led_high_chk: assert property (@(posedge clk) disable iff (rst)
        (tri_c < lvl_q) |=> led);

    // R5
    lvl_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(dly_q) != '0) |-> ($stable(lvl_q) && $stable(idx_q)));

    // R7
    lvl_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(lvl_q)) |->
        (lvl_q == LVL_W'($past(lvl_q) + 1'b1) || lvl_q == LVL_W'($past(lvl_q) - 1'b1)));

    // R6
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(idx_q)) |-> ($stable(lvl_q) && idx_q == IDX_W'($past(idx_q) + 1'b1)));
endmodule

bind breathe_pwm breathe_pwm_chk #(.LVL_W(LVL_W), .IDX_W(IDX_W), .DLY_W(DLY_W)) chk_i (
    .clk(clk), .rst(rst), .led(led), .cnt_q(cnt_q),
    .lvl_q(lvl_q), .idx_q(idx_q), .dly_q(dly_q)
);

// File: tb/breathe_pwm_tb_top.sv
module breathe_pwm_tb_top;
    localparam int         DLY_W = 3;
    localparam logic [55:0] SP   = {7'd3, 7'd120, 7'd120, 7'd127, 7'd0, 7'd14, 7'd14, 7'd10};

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic led;

    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    item_t q[$];

    // reference state, from the requirements
    logic [7:0]       m_cnt;
    logic [DLY_W-1:0] m_dly;
    logic [2:0]       m_idx;
    logic [6:0]       m_lvl;
    logic             m_led;
    int               wraps = 0;

    always #5 clk = ~clk;

    breathe_pwm #(.DLY_W(DLY_W), .SETPTS(SP)) dut_i (
        .clk(clk), .rst(rst), .led(led)
    );

    // R4: set point k sits at bits 7k+6..7k
    function automatic logic [6:0] sp(input logic [2:0] k);
        return SP[k*7 +: 7];
    endfunction

    task automatic model_reset();
        m_cnt = '0; m_dly = '0; m_idx = '0; m_lvl = sp(3'd0); m_led = 1'b0;
    endtask

    task automatic step();
        item_t      it;
        logic [6:0] tv;
        logic [2:0] nx;
        logic [6:0] n_lvl;
        logic [2:0] n_idx;
        @(posedge clk);
        if (rst) begin
            model_reset();
            it.tag = "R1";
        end else begin
            // R2 triangle fold
            tv = m_cnt[7] ? ~m_cnt[6:0] : m_cnt[6:0];
            it.tag = (tv == m_lvl) ? "R3" : "R2";
            if (tv > m_lvl)      m_led = 1'b0;
            else if (tv < m_lvl) m_led = 1'b1;
            n_lvl = m_lvl;
            n_idx = m_idx;
            nx = m_idx + 3'd1;
            if (m_dly == '0) begin
                if (m_lvl == sp(nx)) begin
                    n_idx = nx;
                    if (sp(m_idx) == sp(nx)) it.tag = "R8";
                    else                     it.tag = "R6";
                    if (nx == 3'd0) wraps++;
                end else if (sp(m_idx) < sp(nx)) begin
                    n_lvl = m_lvl + 7'd1; it.tag = "R7";
                end else if (sp(m_idx) > sp(nx)) begin
                    n_lvl = m_lvl - 7'd1; it.tag = "R7";
                end
            end else if (it.tag == "R2") begin
                it.tag = "R5";
            end
            m_lvl = n_lvl;
            m_idx = n_idx;
            m_cnt = m_cnt + 8'd1;
            m_dly = m_dly + 1'b1;
        end
        it.exp = m_led;
        q.push_back(it);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic set_rst(input logic v);
        @(negedge clk);
        rst = v;
    endtask

    // monitor: compares away from the active edge
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                it = q.pop_front();
                n_run++;
                if (led !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s at %0t: led=%b expected %b", it.tag, $time, led, it.exp);
                end
            end
        end
    end

    initial begin
        model_reset();
        run(3);                 // R1 reset state
        set_rst(1'b0);
        run(5000);              // full list, wraps included
        set_rst(1'b1);
        run(2);                 // R1 mid-run reset
        set_rst(1'b0);
        run(2500);
        @(negedge clk);
        @(negedge clk);
        n_run++;
        if (wraps < 2) begin
            n_fail++;
            $display("FAIL R6: wraps seen=%0d expected>=2", wraps);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule